// File: doc/BRIEF.md
# Sixteen-Bit Pair-Register Datapath

This block is the wide arithmetic and pointer path of an 8-bit CPU that keeps two byte accumulators. The accumulators, called A and B, also act together as one 16-bit register D, with A as the upper byte and B as the lower byte. Three pointer registers sit beside them: two index registers X and Y and a stack pointer S. The block also holds the four condition flags N (negative), Z (zero), V (signed overflow) and C (carry or borrow).

A sequencer outside the block decodes each instruction into a 5-bit operation code. It supplies any 16-bit memory operand and raises `start` for one cycle. The block then loads, adds, compares, shifts, swaps, transfers, increments or decrements its registers, and pulses `done` on the next cycle. Each operation has its own rule for which flags it changes. Fetch, opcode decode, the memory bus and push or pull sequencing stay outside the block.

Top module: `dacc_unit`

## Requirements
- R1: When `rst_n` is low at a clock edge, A, B, X, Y, S, the four flags and `done` all become 0.
- R2: `done` is high in exactly the cycle after a cycle with `start` high, and every register write appears in that same cycle. Without `start`, no register and no flag changes.
- R3: The load codes are 0 (D), 1 (X), 2 (Y) and 3 (S). A load copies `operand` into the register, sets N from bit 15 of the result and Z when the result is zero, clears V, and keeps C.
- R4: Code 4 adds `operand` to D. C is the carry out of bit 15. V is set when both inputs have the same sign and the sum has the other sign. N and Z follow the sum.
- R5: Code 5 compares D with `operand`, and code 6 compares Y with `operand`. Each computes register minus operand and sets N, Z and V from the difference. C is set on an unsigned borrow. The register keeps its value.
- R6: Code 7 shifts D right by one bit and puts a zero into bit 15. C takes the bit shifted out of bit 0, N becomes 0, Z follows the result, and V equals N XOR C.
- R7: Code 8 shifts D left by one bit and puts a zero into bit 0. C takes the bit shifted out of bit 15, N is bit 15 of the result, Z follows the result, and V equals N XOR C.
- R8: Code 9 adds B, zero-extended, to X modulo 2^16, and code 10 does the same into Y. No flag changes.
- R9: Code 11 swaps D and X, and code 12 swaps D and Y. All 16 bits move and no flag changes.
- R10: Code 13 writes S+1 into X, and code 14 writes X-1 into S, both modulo 2^16. No flag changes.
- R11: Codes 15 and 16 increment and decrement X, and codes 17 and 18 do the same for Y, modulo 2^16. Z is set when the result is zero. N, V and C keep their values.
- R12: Codes 19 and 20 increment and decrement S modulo 2^16. No flag changes.
- R13: Codes 21 to 31 change no register and no flag, but `done` still pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Runs the operation given on `op` |
| op | input | 5 | Decoded operation code |
| operand | input | 16 | Memory operand for loads, add and compares |
| acc_a | output | 8 | Accumulator A, the upper byte of D |
| acc_b | output | 8 | Accumulator B, the lower byte of D |
| idx_x | output | 16 | Index register X |
| idx_y | output | 16 | Index register Y |
| stk_p | output | 16 | Stack pointer |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry or borrow flag |
| done | output | 1 | Pulses one cycle after `start` |

## Verification
The embedded assertions check, on every cycle, the rules that need only the previous cycle:
- the `done` timing and the hold of all state while idle;
- how loads treat V and C;
- full swaps of D with X;
- the forced N and V=N^C after a right shift;
- the preserved N, V and C on an index increment;
- the plus-one and minus-one transfers between X and S;
- the inert unused codes.

Only the bench's scenarios show the actual 16-bit sums and differences and the signed overflow and borrow results. The same applies to modulo wrap of pointers at 0000 and FFFF, the zero-extension of B, and a reset that arrives after the registers hold data.

// File: rtl/dacc_pkg.sv
// Shared definitions for the pair-register datapath.
// Assumes an operation code of OP_W bits; codes above OP_DEC_S are unassigned.
package dacc_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_LD_D   = 5'd0,
        OP_LD_X   = 5'd1,
        OP_LD_Y   = 5'd2,
        OP_LD_S   = 5'd3,
        OP_ADD_D  = 5'd4,
        OP_CMP_D  = 5'd5,
        OP_CMP_Y  = 5'd6,
        OP_LSR_D  = 5'd7,
        OP_ASL_D  = 5'd8,
        OP_ADD_BX = 5'd9,
        OP_ADD_BY = 5'd10,
        OP_XCH_DX = 5'd11,
        OP_XCH_DY = 5'd12,
        OP_S_TO_X = 5'd13,
        OP_X_TO_S = 5'd14,
        OP_INC_X  = 5'd15,
        OP_DEC_X  = 5'd16,
        OP_INC_Y  = 5'd17,
        OP_DEC_Y  = 5'd18,
        OP_INC_S  = 5'd19,
        OP_DEC_S  = 5'd20
    } dacc_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } dacc_flags_t;

endpackage

// File: rtl/dacc_step.sv
// Plus-one and minus-one unit for a single pointer register.
// Purely combinational. Both results wrap modulo 2^W.
module dacc_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    output logic [W-1:0] val_inc,
    output logic [W-1:0] val_dec
);

    // Form both neighbours of the pointer value.
    always_comb begin
        val_inc = val + W'(1);
        val_dec = val - W'(1);
    end

endmodule

// File: rtl/dacc_alu.sv
// Next-state logic for the pair-register datapath.
// Takes the current registers and flags and returns the values they would
// hold after the operation `op`. Pointer neighbours come from dacc_step units.
// Assumes W is even: B is the lower half of D.
module dacc_alu
    import dacc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    operand,
    input  logic [W-1:0]    d_cur,
    input  logic [W-1:0]    x_cur,
    input  logic [W-1:0]    y_cur,
    input  logic [W-1:0]    s_cur,
    input  dacc_flags_t     fl_cur,
    input  logic [W-1:0]    x_inc,
    input  logic [W-1:0]    x_dec,
    input  logic [W-1:0]    y_inc,
    input  logic [W-1:0]    y_dec,
    input  logic [W-1:0]    s_inc,
    input  logic [W-1:0]    s_dec,
    output logic [W-1:0]    d_nxt,
    output logic [W-1:0]    x_nxt,
    output logic [W-1:0]    y_nxt,
    output logic [W-1:0]    s_nxt,
    output dacc_flags_t     fl_nxt
);

    localparam int HALF = W / 2;

    dacc_op_e       opc;
    logic           is_sub;
    logic [W-1:0]   lhs;
    logic [W-1:0]   rhs;
    logic [W:0]     sum;
    logic           ar_v;
    logic           ar_c;
    logic [W-1:0]   b_ext;
    logic [W-1:0]   shr;
    logic [W-1:0]   shl;

    // Shared adder: add for D, or subtract for the compares of D and Y.
    always_comb begin
        opc    = dacc_op_e'(op);
        is_sub = (opc == OP_CMP_D) || (opc == OP_CMP_Y);
        lhs    = (opc == OP_CMP_Y) ? y_cur : d_cur;
        rhs    = is_sub ? ~operand : operand;
        sum    = {1'b0, lhs} + {1'b0, rhs} + {{W{1'b0}}, is_sub};
        ar_v   = (lhs[W-1] == rhs[W-1]) && (sum[W-1] != lhs[W-1]);
        ar_c   = is_sub ? ~sum[W] : sum[W];
    end

    // Zero-extended B and the two one-bit shifts of D.
    always_comb begin
        b_ext = {{(W-HALF){1'b0}}, d_cur[HALF-1:0]};
        shr   = {1'b0, d_cur[W-1:1]};
        shl   = {d_cur[W-2:0], 1'b0};
    end

    // Choose the next register and flag values for each operation code.
    always_comb begin
        d_nxt  = d_cur;
        x_nxt  = x_cur;
        y_nxt  = y_cur;
        s_nxt  = s_cur;
        fl_nxt = fl_cur;
        case (opc)
            OP_LD_D, OP_LD_X, OP_LD_Y, OP_LD_S: begin
                if (opc == OP_LD_D) d_nxt = operand;
                if (opc == OP_LD_X) x_nxt = operand;
                if (opc == OP_LD_Y) y_nxt = operand;
                if (opc == OP_LD_S) s_nxt = operand;
                fl_nxt.n = operand[W-1];
                fl_nxt.z = (operand == '0);
                fl_nxt.v = 1'b0;
            end
            OP_ADD_D: begin
                d_nxt    = sum[W-1:0];
                fl_nxt.n = sum[W-1];
                fl_nxt.z = (sum[W-1:0] == '0);
                fl_nxt.v = ar_v;
                fl_nxt.c = ar_c;
            end
            OP_CMP_D, OP_CMP_Y: begin
                fl_nxt.n = sum[W-1];
                fl_nxt.z = (sum[W-1:0] == '0);
                fl_nxt.v = ar_v;
                fl_nxt.c = ar_c;
            end
            OP_LSR_D: begin
                d_nxt    = shr;
                fl_nxt.n = 1'b0;
                fl_nxt.z = (shr == '0);
                fl_nxt.c = d_cur[0];
                fl_nxt.v = d_cur[0];
            end
            OP_ASL_D: begin
                d_nxt    = shl;
                fl_nxt.n = shl[W-1];
                fl_nxt.z = (shl == '0);
                fl_nxt.c = d_cur[W-1];
                fl_nxt.v = shl[W-1] ^ d_cur[W-1];
            end
            OP_ADD_BX: x_nxt = x_cur + b_ext;
            OP_ADD_BY: y_nxt = y_cur + b_ext;
            OP_XCH_DX: begin
                d_nxt = x_cur;
                x_nxt = d_cur;
            end
            OP_XCH_DY: begin
                d_nxt = y_cur;
                y_nxt = d_cur;
            end
            OP_S_TO_X: x_nxt = s_inc;
            OP_X_TO_S: s_nxt = x_dec;
            OP_INC_X: begin
                x_nxt    = x_inc;
                fl_nxt.z = (x_inc == '0);
            end
            OP_DEC_X: begin
                x_nxt    = x_dec;
                fl_nxt.z = (x_dec == '0);
            end
            OP_INC_Y: begin
                y_nxt    = y_inc;
                fl_nxt.z = (y_inc == '0);
            end
            OP_DEC_Y: begin
                y_nxt    = y_dec;
                fl_nxt.z = (y_dec == '0);
            end
            OP_INC_S: s_nxt = s_inc;
            OP_DEC_S: s_nxt = s_dec;
            default: ;
        endcase
    end

endmodule

// File: rtl/dacc_unit.sv
// Top of the pair-register datapath. Holds D (A:B), X, Y, S and the flags.
// Registers every result on a cycle with `start` high and pulses `done` on
// the next cycle. Reset is synchronous and active low.
// Assumes `start` lasts one cycle per operation, though back-to-back
// operations are allowed.
module dacc_unit
    import dacc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    operand,
    output logic [W/2-1:0]  acc_a,
    output logic [W/2-1:0]  acc_b,
    output logic [W-1:0]    idx_x,
    output logic [W-1:0]    idx_y,
    output logic [W-1:0]    stk_p,
    output logic            flag_n,
    output logic            flag_z,
    output logic            flag_v,
    output logic            flag_c,
    output logic            done
);

    localparam int HALF = W / 2;
    localparam int NPTR = 3;
    localparam int PX   = 0;
    localparam int PY   = 1;
    localparam int PS   = 2;

    logic [W-1:0] d_q, x_q, y_q, s_q;
    logic [W-1:0] d_n, x_n, y_n, s_n;
    dacc_flags_t  fl_q, fl_n;
    logic         done_q;

    logic [W-1:0] ptr_val [NPTR];
    logic [W-1:0] ptr_inc [NPTR];
    logic [W-1:0] ptr_dec [NPTR];

    // Gather the pointer registers for the step units.
    always_comb begin
        ptr_val[PX] = x_q;
        ptr_val[PY] = y_q;
        ptr_val[PS] = s_q;
    end

    // One plus/minus-one unit per pointer register.
    for (genvar gi = 0; gi < NPTR; gi++) begin : g_step
        dacc_step #(.W(W)) u_step (
            .val     (ptr_val[gi]),
            .val_inc (ptr_inc[gi]),
            .val_dec (ptr_dec[gi])
        );
    end

    dacc_alu #(.W(W)) u_alu (
        .op      (op),
        .operand (operand),
        .d_cur   (d_q),
        .x_cur   (x_q),
        .y_cur   (y_q),
        .s_cur   (s_q),
        .fl_cur  (fl_q),
        .x_inc   (ptr_inc[PX]),
        .x_dec   (ptr_dec[PX]),
        .y_inc   (ptr_inc[PY]),
        .y_dec   (ptr_dec[PY]),
        .s_inc   (ptr_inc[PS]),
        .s_dec   (ptr_dec[PS]),
        .d_nxt   (d_n),
        .x_nxt   (x_n),
        .y_nxt   (y_n),
        .s_nxt   (s_n),
        .fl_nxt  (fl_n)
    );

    // State registers: clear on reset, take the new values on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_q    <= '0;
            x_q    <= '0;
            y_q    <= '0;
            s_q    <= '0;
            fl_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= start;
            if (start) begin
                d_q  <= d_n;
                x_q  <= x_n;
                y_q  <= y_n;
                s_q  <= s_n;
                fl_q <= fl_n;
            end
        end
    end

    // Drive the outputs from the state.
    always_comb begin
        acc_a  = d_q[W-1:HALF];
        acc_b  = d_q[HALF-1:0];
        idx_x  = x_q;
        idx_y  = y_q;
        stk_p  = s_q;
        flag_n = fl_q.n;
        flag_z = fl_q.z;
        flag_v = fl_q.v;
        flag_c = fl_q.c;
        done   = done_q;
    end

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (!done && $stable({acc_a, acc_b, idx_x, idx_y, stk_p,
                                      flag_n, flag_z, flag_v, flag_c})));

    // R3
    load_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == OP_LD_X) |=> (idx_x == $past(operand) && !flag_v
            && flag_c == $past(flag_c) && flag_n == idx_x[W-1]));

    // R6
    lsrd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == OP_LSR_D) |=> (!flag_n && flag_v == flag_c
            && flag_c == $past(acc_b[0])));

    // R9
    xchg_dx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == OP_XCH_DX) |=> (idx_x == $past({acc_a, acc_b})
            && {acc_a, acc_b} == $past(idx_x)
            && $stable({flag_n, flag_z, flag_v, flag_c})));

    // R10
    sp_to_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == OP_S_TO_X) |=> (idx_x == $past(stk_p) + W'(1)
            && $stable({flag_n, flag_z, flag_v, flag_c})));

    // R10
    x_to_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == OP_X_TO_S) |=> (stk_p == $past(idx_x) - W'(1)));

    // R11
    incx_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == OP_INC_X) |=> (idx_x == $past(idx_x) + W'(1)
            && $stable({flag_n, flag_v, flag_c}) && flag_z == (idx_x == '0)));

    // R13
    spare_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op > OP_DEC_S) |=> $stable({acc_a, acc_b, idx_x, idx_y,
            stk_p, flag_n, flag_z, flag_v, flag_c}));

endmodule

// File: tb/tb_dacc_unit.sv
// Vector-table bench for dacc_unit, followed by directed reset and idle tests.
module tb_dacc_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  op = '0;
    logic [15:0] operand = '0;
    logic [7:0]  acc_a, acc_b;
    logic [15:0] idx_x, idx_y, stk_p;
    logic        flag_n, flag_z, flag_v, flag_c, done;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dacc_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .operand(operand),
        .acc_a(acc_a), .acc_b(acc_b), .idx_x(idx_x), .idx_y(idx_y),
        .stk_p(stk_p), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
        .flag_c(flag_c), .done(done)
    );

    // Row: {req[3:0], op[4:0], operand, D, X, Y, S, NZVC} after the step.
    localparam int NV = 38;
    localparam logic [92:0] VEC [0:NV-1] = '{
        {4'd3,  5'd0,  16'h8001, 16'h8001, 16'h0000, 16'h0000, 16'h0000, 4'b1000}, // R3 load D
        {4'd3,  5'd1,  16'h1234, 16'h8001, 16'h1234, 16'h0000, 16'h0000, 4'b0000}, // R3 load X
        {4'd3,  5'd2,  16'h0000, 16'h8001, 16'h1234, 16'h0000, 16'h0000, 4'b0100}, // R3 load Y zero
        {4'd3,  5'd3,  16'h00FF, 16'h8001, 16'h1234, 16'h0000, 16'h00FF, 4'b0000}, // R3 load S
        {4'd4,  5'd4,  16'h8000, 16'h0001, 16'h1234, 16'h0000, 16'h00FF, 4'b0011}, // R4 neg+neg
        {4'd3,  5'd1,  16'hFFFF, 16'h0001, 16'hFFFF, 16'h0000, 16'h00FF, 4'b1001}, // R3 C kept
        {4'd4,  5'd4,  16'h7FFF, 16'h8000, 16'hFFFF, 16'h0000, 16'h00FF, 4'b1010}, // R4 pos+pos
        {4'd5,  5'd5,  16'h8000, 16'h8000, 16'hFFFF, 16'h0000, 16'h00FF, 4'b0100}, // R5 cmp D equal
        {4'd5,  5'd6,  16'h0001, 16'h8000, 16'hFFFF, 16'h0000, 16'h00FF, 4'b1001}, // R5 cmp Y borrow
        {4'd6,  5'd7,  16'h0000, 16'h4000, 16'hFFFF, 16'h0000, 16'h00FF, 4'b0000}, // R6
        {4'd7,  5'd8,  16'h0000, 16'h8000, 16'hFFFF, 16'h0000, 16'h00FF, 4'b1010}, // R7
        {4'd7,  5'd8,  16'h0000, 16'h0000, 16'hFFFF, 16'h0000, 16'h00FF, 4'b0111}, // R7 out of bit 15
        {4'd6,  5'd7,  16'h0000, 16'h0000, 16'hFFFF, 16'h0000, 16'h00FF, 4'b0100}, // R6 zero
        {4'd3,  5'd0,  16'h12F0, 16'h12F0, 16'hFFFF, 16'h0000, 16'h00FF, 4'b0000}, // R3
        {4'd8,  5'd9,  16'h0000, 16'h12F0, 16'h00EF, 16'h0000, 16'h00FF, 4'b0000}, // R8 wrap
        {4'd8,  5'd10, 16'h0000, 16'h12F0, 16'h00EF, 16'h00F0, 16'h00FF, 4'b0000}, // R8
        {4'd9,  5'd11, 16'h0000, 16'h00EF, 16'h12F0, 16'h00F0, 16'h00FF, 4'b0000}, // R9 D<->X
        {4'd9,  5'd12, 16'h0000, 16'h00F0, 16'h12F0, 16'h00EF, 16'h00FF, 4'b0000}, // R9 D<->Y
        {4'd10, 5'd13, 16'h0000, 16'h00F0, 16'h0100, 16'h00EF, 16'h00FF, 4'b0000}, // R10 S+1
        {4'd11, 5'd16, 16'h0000, 16'h00F0, 16'h00FF, 16'h00EF, 16'h00FF, 4'b0000}, // R11 dec X
        {4'd10, 5'd14, 16'h0000, 16'h00F0, 16'h00FF, 16'h00EF, 16'h00FE, 4'b0000}, // R10 X-1
        {4'd3,  5'd2,  16'h0001, 16'h00F0, 16'h00FF, 16'h0001, 16'h00FE, 4'b0000}, // R3
        {4'd5,  5'd6,  16'h0002, 16'h00F0, 16'h00FF, 16'h0001, 16'h00FE, 4'b1001}, // R5
        {4'd11, 5'd18, 16'h0000, 16'h00F0, 16'h00FF, 16'h0000, 16'h00FE, 4'b1101}, // R11 dec Y
        {4'd11, 5'd17, 16'h0000, 16'h00F0, 16'h00FF, 16'h0001, 16'h00FE, 4'b1001}, // R11 inc Y
        {4'd11, 5'd15, 16'h0000, 16'h00F0, 16'h0100, 16'h0001, 16'h00FE, 4'b1001}, // R11 inc X
        {4'd3,  5'd1,  16'hFFFF, 16'h00F0, 16'hFFFF, 16'h0001, 16'h00FE, 4'b1001}, // R3
        {4'd11, 5'd15, 16'h0000, 16'h00F0, 16'h0000, 16'h0001, 16'h00FE, 4'b1101}, // R11 wrap
        {4'd12, 5'd19, 16'h0000, 16'h00F0, 16'h0000, 16'h0001, 16'h00FF, 4'b1101}, // R12 inc S
        {4'd12, 5'd20, 16'h0000, 16'h00F0, 16'h0000, 16'h0001, 16'h00FE, 4'b1101}, // R12 dec S
        {4'd13, 5'd21, 16'hFFFF, 16'h00F0, 16'h0000, 16'h0001, 16'h00FE, 4'b1101}, // R13
        {4'd3,  5'd3,  16'h0000, 16'h00F0, 16'h0000, 16'h0001, 16'h0000, 4'b0101}, // R3
        {4'd12, 5'd20, 16'h0000, 16'h00F0, 16'h0000, 16'h0001, 16'hFFFF, 4'b0101}, // R12 wrap
        {4'd10, 5'd13, 16'h0000, 16'h00F0, 16'h0000, 16'h0001, 16'hFFFF, 4'b0101}, // R10 wrap
        {4'd3,  5'd1,  16'h0005, 16'h00F0, 16'h0005, 16'h0001, 16'hFFFF, 4'b0001}, // R3
        {4'd10, 5'd14, 16'h0000, 16'h00F0, 16'h0005, 16'h0001, 16'h0004, 4'b0001}, // R10
        {4'd12, 5'd19, 16'h0000, 16'h00F0, 16'h0005, 16'h0001, 16'h0005, 4'b0001}, // R12
        {4'd13, 5'd31, 16'h1234, 16'h00F0, 16'h0005, 16'h0001, 16'h0005, 4'b0001}  // R13 top code
    };

    // Compare one observed value with its expected value.
    task automatic chk(input int req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Compare all of the state against one expected snapshot.
    task automatic chk_state(input int req, input logic [15:0] d,
                             input logic [15:0] x, input logic [15:0] y,
                             input logic [15:0] s, input logic [3:0] f);
        chk(req, "D", {acc_a, acc_b}, d);
        chk(req, "X", idx_x, x);
        chk(req, "Y", idx_y, y);
        chk(req, "S", stk_p, s);
        chk(req, "NZVC", {12'd0, flag_n, flag_z, flag_v, flag_c}, {12'd0, f});
    endtask

    // Run one operation: drive at a falling edge, sample at the next falling edge.
    task automatic run(input logic [4:0] o, input logic [15:0] v, input int req);
        @(negedge clk);
        op = o;
        operand = v;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(req, "done", {15'd0, done}, 16'd1);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R2 watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk_state(1, 16'h0, 16'h0, 16'h0, 16'h0, 4'b0000);
        chk(1, "done", {15'd0, done}, 16'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run(VEC[i][88:84], VEC[i][83:68], int'(VEC[i][92:89]));
            chk_state(int'(VEC[i][92:89]), VEC[i][67:52], VEC[i][51:36],
                      VEC[i][35:20], VEC[i][19:4], VEC[i][3:0]);
        end

        // R2: with start low, done drops and state holds while inputs move.
        op = 5'd0;
        operand = 16'hAAAA;
        @(negedge clk);
        chk(2, "done idle", {15'd0, done}, 16'd0);
        @(negedge clk);
        chk_state(2, 16'h00F0, 16'h0005, 16'h0001, 16'h0005, 4'b0001);

        // R2: back-to-back starts, each result visible a cycle later.
        @(negedge clk);
        op = 5'd0; operand = 16'h7FFF; start = 1'b1;
        @(negedge clk);
        chk(2, "b2b D1", {acc_a, acc_b}, 16'h7FFF);
        op = 5'd4; operand = 16'h0001;
        @(negedge clk);
        start = 1'b0;
        // R4: 7FFF + 0001 overflows into the sign bit.
        chk(4, "b2b D2", {acc_a, acc_b}, 16'h8000);
        chk(4, "b2b NZVC", {12'd0, flag_n, flag_z, flag_v, flag_c}, 16'b1010);
        chk(2, "b2b done", {15'd0, done}, 16'd1);

        // R5: compare of D below the operand sets the borrow.
        run(5'd5, 16'h8001, 5);
        chk(5, "cmp lo D", {acc_a, acc_b}, 16'h8000);
        chk(5, "cmp lo NZVC", {12'd0, flag_n, flag_z, flag_v, flag_c}, 16'b1001);

        // R1: a reset after the registers hold data clears everything.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk_state(1, 16'h0, 16'h0, 16'h0, 16'h0, 4'b0000);
        chk(1, "done rst", {15'd0, done}, 16'd0);
        rst_n = 1'b1;

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule